// File: doc/BRIEF.md
# Rotating Tiled Framebuffer Address Generator

This block turns a stream of source pixels, arriving in scan order, into a stream of destination pixel indices for a framebuffer. Software supplies a packed size word, a quarter-turn rotation code and a tiling switch, then pulses `start`. For each pixel it accepts, the block emits the linear index at which that pixel belongs in the rotated and, if requested, tiled destination image. After the last pixel of the frame it pulses `done` once and goes back to idle.

Both data sides use valid/ready handshakes. The pixel input is accepted only when the index output can be taken in the same cycle, so `pix_ready` follows `idx_ready` while a frame is active and `idx_valid` follows `pix_valid`. A stall on the output holds the input, and the presented index does not change while it waits. The settings are captured when `start` is taken. A `start` pulse during a frame has no effect. If the tiling switch is on and a size is not a multiple of 8, the start is refused and `cfg_err` pulses instead.

Top module: `fb_rot_addr_gen`

## Requirements
- R1: After reset the block is idle: `busy`, `idx_valid`, `pix_ready`, `done` and `cfg_err` are all 0.
- R2: The source width W is one plus `cfg_size[8:0]` and the source height H is one plus `cfg_size[24:16]`, so each lies between 1 and 512. All other bits of `cfg_size` are ignored.
- R3: Source coordinates start at (0,0) and advance in raster order, with x fastest. There is exactly one step per handshake (`pix_valid && pix_ready`).
- R4: `cfg_rot` selects the destination coordinates (dx,dy) and the destination width DW. Code 0 gives (x,y) with DW=W. Code 1 (90° clockwise) gives (H-1-y, x) with DW=H. Code 2 (180°) gives (W-1-x, H-1-y) with DW=W. Code 3 (270° clockwise) gives (y, W-1-x) with DW=H. With tiling off, the index is dy*DW+dx.
- R5: With `cfg_tile`=1, the index is (dy/8)*DW*8 + (dx/8)*64 + (dy%8)*8 + dx%8.
- R6: A `start` with `cfg_tile`=1 and W or H not a multiple of 8 gives a one-cycle `cfg_err` in the next cycle. The block stays idle and accepts no pixels.
- R7: `done` is high for exactly one cycle, in the cycle after the handshake of pixel W*H-1. In that same cycle `busy` is 0.
- R8: While busy, `pix_ready` equals `idx_ready` and `idx_valid` equals `pix_valid`. When no handshake occurs, `idx_data` holds its value.
- R9: `busy` rises in the cycle after an accepted `start`. The settings are captured at that start, and `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_size | input | 32 | Packed size word: width-1 and height-1 |
| cfg_rot | input | 2 | Rotation code 0..3 |
| cfg_tile | input | 1 | Tiled destination layout enable |
| start | input | 1 | Frame launch pulse |
| pix_valid | input | 1 | Source pixel offered |
| pix_ready | output | 1 | Source pixel accepted this cycle |
| idx_valid | output | 1 | Destination index offered |
| idx_ready | input | 1 | Destination index taken |
| idx_data | output | 18 | Destination pixel index |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| cfg_err | output | 1 | One-cycle refused-start pulse |

## Verification
The bench sweeps all four rotation codes over non-square, square, single-pixel, one-row 512-wide and one-column 512-high frames, with and without tiling. It also inserts gaps and output stalls.

Each corner case targets a specific fault:
- Swapping the destination width under rotation would scramble every row after the first.
- Taking the wrong tile stride would only show with multi-tile frames wider than tall.
- An off-by-one in the end-of-row logic would show at W=1 or H=1, or at the 512 extreme.
- A design that ignores back-pressure would skip indices during stalls.
- A design that re-latches settings on a mid-frame `start`, or starts an illegal tiled frame, would emit indices that the bench does not expect.

// File: rtl/fbag_pkg.sv
package fbag_pkg;
  typedef enum logic [1:0] {
    ROT_0   = 2'd0,
    ROT_90  = 2'd1,
    ROT_180 = 2'd2,
    ROT_270 = 2'd3
  } rot_e;
endpackage

// File: rtl/fbag_scan_ctr.sv
module fbag_scan_ctr #(
  parameter int DIM_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [DIM_W-1:0] wm1,
  input  logic [DIM_W-1:0] hm1,
  output logic [DIM_W-1:0] x,
  output logic [DIM_W-1:0] y,
  output logic             last
);
  logic row_end;
  assign row_end = (x == wm1);
  assign last    = row_end && (y == hm1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x <= '0;
      y <= '0;
    end else if (load) begin
      x <= '0;
      y <= '0;
    end else if (step) begin
      if (row_end) begin
        x <= '0;
        y <= y + DIM_W'(1);
      end else begin
        x <= x + DIM_W'(1);
      end
    end
  end
endmodule

// File: rtl/fbag_rotate.sv
module fbag_rotate
  import fbag_pkg::*;
#(
  parameter int DIM_W = 9
) (
  input  rot_e             rot,
  input  logic [DIM_W-1:0] x,
  input  logic [DIM_W-1:0] y,
  input  logic [DIM_W-1:0] wm1,
  input  logic [DIM_W-1:0] hm1,
  output logic [DIM_W-1:0] dx,
  output logic [DIM_W-1:0] dy,
  output logic [DIM_W-1:0] dwm1
);
  always_comb begin
    unique case (rot)
      ROT_90: begin
        dx = hm1 - y;  dy = x;        dwm1 = hm1;
      end
      ROT_180: begin
        dx = wm1 - x;  dy = hm1 - y;  dwm1 = wm1;
      end
      ROT_270: begin
        dx = y;        dy = wm1 - x;  dwm1 = hm1;
      end
      default: begin
        dx = x;        dy = y;        dwm1 = wm1;
      end
    endcase
  end
endmodule

// File: rtl/fbag_linearize.sv
module fbag_linearize #(
  parameter int DIM_W   = 9,
  parameter int TILE_LG = 3,
  parameter int IDX_W   = 2 * DIM_W
) (
  input  logic             tile,
  input  logic [DIM_W-1:0] dx,
  input  logic [DIM_W-1:0] dy,
  input  logic [DIM_W-1:0] dwm1,
  output logic [IDX_W-1:0] idx
);
  localparam logic [DIM_W-1:0] TMASK = DIM_W'((1 << TILE_LG) - 1);

  logic [DIM_W:0]   dest_w;
  logic [IDX_W-1:0] lin_idx, row_base, col_off, in_off;

  assign dest_w   = {1'b0, dwm1} + (DIM_W+1)'(1);
  assign lin_idx  = IDX_W'(dy) * IDX_W'(dest_w) + IDX_W'(dx);
  // one tile row spans dest_w * tile_height pixels
  assign row_base = (IDX_W'(dy >> TILE_LG) * IDX_W'(dest_w)) << TILE_LG;
  assign col_off  = IDX_W'(dx >> TILE_LG) << (2 * TILE_LG);
  assign in_off   = (IDX_W'(dy & TMASK) << TILE_LG) | IDX_W'(dx & TMASK);
  assign idx      = tile ? (row_base + col_off + in_off) : lin_idx;
endmodule

// File: rtl/fb_rot_addr_gen.sv
module fb_rot_addr_gen
  import fbag_pkg::*;
#(
  parameter int DIM_W      = 9,
  parameter int TILE_LG    = 3,
  parameter int SIZE_H_LSB = 16,
  parameter int IDX_W      = 2 * DIM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfg_size,
  input  logic [1:0]       cfg_rot,
  input  logic             cfg_tile,
  input  logic             start,
  input  logic             pix_valid,
  output logic             pix_ready,
  output logic             idx_valid,
  input  logic             idx_ready,
  output logic [IDX_W-1:0] idx_data,
  output logic             busy,
  output logic             done,
  output logic             cfg_err
);
  localparam logic [TILE_LG-1:0] TILE_ONES = '1;

  logic [DIM_W-1:0] wm1_in, hm1_in;
  logic [DIM_W-1:0] wm1_q, hm1_q;
  rot_e             rot_q;
  logic             tile_q, busy_q, done_q, err_q;
  logic             tile_bad, launch, fire, last;
  logic [DIM_W-1:0] x, y, dx, dy, dwm1;

  assign wm1_in   = cfg_size[0 +: DIM_W];
  assign hm1_in   = cfg_size[SIZE_H_LSB +: DIM_W];
  assign tile_bad = cfg_tile && ((wm1_in[TILE_LG-1:0] != TILE_ONES) ||
                                 (hm1_in[TILE_LG-1:0] != TILE_ONES));
  assign launch   = start && !busy_q && !tile_bad;
  assign pix_ready = busy_q && idx_ready;
  assign idx_valid = busy_q && pix_valid;
  assign fire      = pix_valid && pix_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm1_q  <= '0;
      hm1_q  <= '0;
      rot_q  <= ROT_0;
      tile_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q  <= start && !busy_q && tile_bad;
      done_q <= fire && last;
      if (launch) begin
        wm1_q  <= wm1_in;
        hm1_q  <= hm1_in;
        rot_q  <= rot_e'(cfg_rot);
        tile_q <= cfg_tile;
        busy_q <= 1'b1;
      end else if (fire && last) begin
        busy_q <= 1'b0;
      end
    end
  end

  fbag_scan_ctr #(.DIM_W(DIM_W)) scan_i (
    .clk(clk), .rst_n(rst_n), .load(launch), .step(fire),
    .wm1(wm1_q), .hm1(hm1_q), .x(x), .y(y), .last(last)
  );

  fbag_rotate #(.DIM_W(DIM_W)) rot_i (
    .rot(rot_q), .x(x), .y(y), .wm1(wm1_q), .hm1(hm1_q),
    .dx(dx), .dy(dy), .dwm1(dwm1)
  );

  fbag_linearize #(.DIM_W(DIM_W), .TILE_LG(TILE_LG), .IDX_W(IDX_W)) lin_i (
    .tile(tile_q), .dx(dx), .dy(dy), .dwm1(dwm1), .idx(idx_data)
  );

  assign busy    = busy_q;
  assign done    = done_q;
  assign cfg_err = err_q;
endmodule

// File: rtl/fbag_checker.sv
module fbag_checker #(
  parameter int IDX_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             pix_valid,
  input logic             pix_ready,
  input logic             idx_valid,
  input logic             idx_ready,
  input logic [IDX_W-1:0] idx_data,
  input logic             busy,
  input logic             done,
  input logic             cfg_err
);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r6_err_refused: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!busy && !idx_valid));
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(pix_valid && pix_ready)) |=> (busy && $stable(idx_data)));
  a_r8_no_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!pix_ready && !idx_valid));
  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind fb_rot_addr_gen fbag_checker #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid),
  .pix_ready(pix_ready), .idx_valid(idx_valid), .idx_ready(idx_ready),
  .idx_data(idx_data), .busy(busy), .done(done), .cfg_err(cfg_err)
);

// File: tb/fb_rot_addr_gen_tb_top.sv
module fb_rot_addr_gen_tb_top;
  localparam int IDX_W = 18;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [31:0]      cfg_size = '0;
  logic [1:0]       cfg_rot = '0;
  logic             cfg_tile = 1'b0;
  logic             start = 1'b0;
  logic             pix_valid = 1'b0;
  logic             idx_ready = 1'b0;
  logic             pix_ready, idx_valid, busy, done, cfg_err;
  logic [IDX_W-1:0] idx_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fb_rot_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_rot(cfg_rot),
    .cfg_tile(cfg_tile), .start(start), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .idx_valid(idx_valid), .idx_ready(idx_ready),
    .idx_data(idx_data), .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_idx(int w, int h, int rot, bit tile, int x, int y);
    int dx, dy, dw;
    case (rot)
      1: begin dx = h - 1 - y; dy = x;         dw = h; end
      2: begin dx = w - 1 - x; dy = h - 1 - y; dw = w; end
      3: begin dx = y;         dy = w - 1 - x; dw = h; end
      default: begin dx = x;   dy = y;         dw = w; end
    endcase
    if (!tile) return dy * dw + dx;
    return (dy / 8) * dw * 8 + (dx / 8) * 64 + (dy % 8) * 8 + (dx % 8);
  endfunction

  // R2: pack width-1 and height-1, optionally with junk in ignored bits
  function automatic logic [31:0] pack(int w, int h, bit junk);
    logic [31:0] v;
    v = 32'((h - 1) << 16) | 32'(w - 1);
    if (junk) v = v | 32'h4200_1C00 | 32'h0200_0000;
    return v;
  endfunction

  task automatic run_frame(int w, int h, int rot, bit tile, bit junk, bit stall);
    int x = 0, y = 0, n = 0, cyc = 0;
    @(negedge clk);
    cfg_size = pack(w, h, junk); cfg_rot = 2'(rot); cfg_tile = tile; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1 chk("R9 busy after start", busy, 1);
    while (n < w * h) begin
      @(negedge clk);
      pix_valid = stall ? ((cyc % 3) != 2) : 1'b1;
      idx_ready = stall ? ((cyc % 5) != 4) : 1'b1;
      // R9: a mid-frame start with other settings must be ignored
      start = (n == 1);
      if (n == 1) begin
        cfg_size = pack(7, 3, 0); cfg_rot = 2'(rot + 1); cfg_tile = ~tile;
      end
      #1;
      if (busy) chk("R8 ready follows", pix_ready, idx_ready);
      if (pix_valid) chk("R8 valid follows", idx_valid, 1);
      if (pix_valid && idx_ready) begin
        chk(tile ? "R5 tiled index" : "R4 R3 index", idx_data,
            exp_idx(w, h, rot, tile, x, y));
        n++;
        if (x == w - 1) begin x = 0; y++; end else x++;
      end
      cyc++;
    end
    @(negedge clk);
    pix_valid = 1'b0; start = 1'b0;
    #1 chk("R7 done pulse", done, 1);
    chk("R7 idle at done", busy, 0);
    @(negedge clk);
    #1 chk("R7 done one cycle", done, 0);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    #35 rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 busy", busy, 0);
    chk("R1 idx_valid", idx_valid, 0);
    chk("R1 pix_ready", pix_ready, 0);
    chk("R1 done", done, 0);
    chk("R1 cfg_err", cfg_err, 0);

    for (int r = 0; r < 4; r++) begin
      run_frame(8, 8, r, 0, 0, 0);
      run_frame(8, 8, r, 1, 0, 1);
      run_frame(16, 8, r, 1, 1, 1);
      run_frame(8, 24, r, 1, 0, 0);
      run_frame(3, 5, r, 0, 1, 1);
      run_frame(1, 1, r, 0, 0, 0);
    end
    run_frame(512, 1, 0, 0, 0, 0);
    run_frame(512, 1, 1, 0, 0, 1);
    run_frame(1, 512, 3, 0, 1, 0);
    run_frame(1, 512, 2, 0, 0, 0);

    // R6: tiled start with a width that is not a multiple of 8
    @(negedge clk);
    cfg_size = pack(12, 8, 0); cfg_rot = 2'd0; cfg_tile = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; pix_valid = 1'b1; idx_ready = 1'b1;
    #1 chk("R6 err pulse", cfg_err, 1);
    chk("R6 stays idle", busy, 0);
    chk("R6 no pixel taken", pix_ready, 0);
    @(negedge clk);
    #1 chk("R6 err one cycle", cfg_err, 0);
    chk("R6 no index", idx_valid, 0);
    pix_valid = 1'b0;
    // R6: height not a multiple of 8
    @(negedge clk);
    cfg_size = pack(8, 10, 0); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1 chk("R6 err height", cfg_err, 1);
    chk("R6 idle height", busy, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule